// File: doc/BRIEF.md
# Multi-Mode Multiplier Unit

This block is the multiply unit of a small 8-bit processor core. Each request brings two 8-bit operands and a 3-bit mode code. The unit returns a 16-bit product and two flags, zero and carry. The mode code selects how the operands are read: both unsigned, both two's complement, or the first signed and the second unsigned. A separate mode bit selects a fractional variant of each of these, which doubles the product by shifting it left one place.

A one-cycle `start` pulse launches an operation. Two clock edges later `done` pulses for one cycle, with `result`, `z` and `c` valid. The core writes `result[15:8]` into register 1 and `result[7:0]` into register 0. This register pair is fixed and does not depend on which registers supplied the operands. The pipeline takes a new `start` on every cycle, so back-to-back multiplies complete on consecutive cycles. The core leaves every status flag other than zero and carry untouched, so the unit drives only those two.

Top module: `mmul_unit`

## Requirements
- R1: Mode code 0 reads `a` and `b` as unsigned and returns their 16-bit product.
- R2: Mode code 1 reads `a` and `b` as two's complement and returns the 16-bit two's-complement product.
- R3: Mode codes 2 and 3 read `a` as two's complement and `b` as unsigned. Mode codes 6 and 7 use the same operand reading in fractional form.
- R4: When mode bit 2 is set, `result` is the integer product of the mode selected by bits 1:0, shifted left one bit, with a 0 entering bit 0 and the old bit 15 lost.
- R5: `done` is high exactly two cycles after the cycle in which `start` was sampled high, for one cycle per start, including when starts are on consecutive cycles. `result[15:8]` is the byte written to register 1 and `result[7:0]` is the byte written to register 0.
- R6: On `done`, `c` equals bit 15 of the integer product before any fractional shift.
- R7: On `done`, `z` is 1 exactly when the final 16-bit `result` is zero.
- R8: Fractional signed mode (code 5) with `a` = `b` = 0x80 returns 0x8000 with `c` = 0 and `z` = 0.
- R9: In any cycle without `done`, `result`, `z` and `c` keep their previous values, and a cycle with `start` low produces no `done`.
- R10: While `rst_n` is low, `done`, `z`, `c` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch an operation with the current mode and operands |
| mode | input | 3 | Bit 2: fractional. Bits 1:0: 0 unsigned, 1 signed, 2 or 3 signed-by-unsigned |
| a | input | 8 | First operand |
| b | input | 8 | Second operand |
| result | output | 16 | Product; high byte to register 1, low byte to register 0 |
| z | output | 1 | Zero flag of the final result |
| c | output | 1 | Carry flag, bit 15 of the unshifted product |
| done | output | 1 | One-cycle pulse marking a valid result |

## Verification
Two things can happen in the same cycle: a new operation is accepted while an earlier one is still in flight, and the earlier one is delivered. Runs of `start` on consecutive cycles create this overlap, with a different mode and operand pair on each cycle, including fractional and non-fractional modes next to each other. The reference model keeps a queue of expected results, each due two cycles after its start, and compares `done`, `result`, `z` and `c` on every clock. Any pipeline stage that mixes its mode or operands with its neighbour's therefore shows up as a wrong value in that exact cycle.

// File: rtl/mmul_pkg.sv
package mmul_pkg;

   typedef enum logic [2:0] {
      MM_UU      = 3'd0,
      MM_SS      = 3'd1,
      MM_SU      = 3'd2,
      MM_SU_ALT  = 3'd3,
      MM_FUU     = 3'd4,
      MM_FSS     = 3'd5,
      MM_FSU     = 3'd6,
      MM_FSU_ALT = 3'd7
   } mm_mode_e;

   // first operand is signed in every mode whose low bits are nonzero
   function automatic logic mm_a_signed(input logic [2:0] m);
      return m[1] | m[0];
   endfunction

   // second operand is signed only in the plain signed code
   function automatic logic mm_b_signed(input logic [2:0] m);
      return m[0] & ~m[1];
   endfunction

   function automatic logic mm_is_frac(input logic [2:0] m);
      return m[2];
   endfunction

endpackage

// File: rtl/mmul_operand_stage.sv
module mmul_operand_stage
   import mmul_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [2:0]   mode,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         v1,
   output logic         frac1,
   output logic [W:0]   xa,
   output logic [W:0]   xb
);

   logic [W:0] xa_n;
   logic [W:0] xb_n;

   // one extra bit turns every reading into a single signed form
   always_comb begin
      xa_n = {mm_a_signed(mode) & a[W-1], a};
      xb_n = {mm_b_signed(mode) & b[W-1], b};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1    <= 1'b0;
         frac1 <= 1'b0;
         xa    <= '0;
         xb    <= '0;
      end else begin
         v1 <= start;
         if (start) begin
            frac1 <= mm_is_frac(mode);
            xa    <= xa_n;
            xb    <= xb_n;
         end
      end
   end

endmodule

// File: rtl/mmul_core.sv
module mmul_core #(
   parameter int W         = 8,
   parameter bit USE_ARRAY = 1'b1
) (
   input  logic [W:0]     xa,
   input  logic [W:0]     xb,
   output logic [2*W-1:0] raw
);

   localparam int PW = 2 * W;

   // operand a sign-extended to the product width; wrap modulo 2^PW is exact
   logic [PW-1:0] ea;
   assign ea = {{(PW-W-1){xa[W]}}, xa};

   if (USE_ARRAY) begin : g_array
      logic [PW-1:0] acc [W+2];
      assign acc[0] = '0;
      for (genvar i = 0; i <= W; i++) begin : g_row
         logic [PW-1:0] pp;
         assign pp = xb[i] ? (ea << i) : '0;
         if (i == W) begin : g_neg
            // top bit of the extended operand carries negative weight
            assign acc[i+1] = acc[i] - pp;
         end else begin : g_pos
            assign acc[i+1] = acc[i] + pp;
         end
      end
      assign raw = acc[W+1];
   end else begin : g_operator
      logic [PW-1:0] eb;
      assign eb  = {{(PW-W-1){xb[W]}}, xb};
      assign raw = ea * eb;
   end

endmodule

// File: rtl/mmul_result_stage.sv
module mmul_result_stage #(
   parameter int W = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           v1,
   input  logic           frac1,
   input  logic [2*W-1:0] raw,
   output logic [2*W-1:0] result,
   output logic           z,
   output logic           c,
   output logic           done
);

   localparam int PW = 2 * W;

   logic [PW-1:0] res_n;
   logic          z_n;
   logic          c_n;

   always_comb begin
      c_n   = raw[PW-1];
      res_n = frac1 ? {raw[PW-2:0], 1'b0} : raw;
      z_n   = ~|res_n;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result <= '0;
         z      <= 1'b0;
         c      <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= v1;
         if (v1) begin
            result <= res_n;
            z      <= z_n;
            c      <= c_n;
         end
      end
   end

endmodule

// File: rtl/mmul_unit.sv
module mmul_unit #(
   parameter int W         = 8,
   parameter bit USE_ARRAY = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [2:0]     mode,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [2*W-1:0] result,
   output logic           z,
   output logic           c,
   output logic           done
);

   if (W < 2) begin : g_w_check
      $error("mmul_unit: W must be at least 2");
   end

   logic         v1;
   logic         frac1;
   logic [W:0]   xa;
   logic [W:0]   xb;
   logic [2*W-1:0] raw;

   mmul_operand_stage #(.W(W)) u_opnd (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .mode  (mode),
      .a     (a),
      .b     (b),
      .v1    (v1),
      .frac1 (frac1),
      .xa    (xa),
      .xb    (xb)
   );

   mmul_core #(.W(W), .USE_ARRAY(USE_ARRAY)) u_core (
      .xa  (xa),
      .xb  (xb),
      .raw (raw)
   );

   mmul_result_stage #(.W(W)) u_res (
      .clk    (clk),
      .rst_n  (rst_n),
      .v1     (v1),
      .frac1  (frac1),
      .raw    (raw),
      .result (result),
      .z      (z),
      .c      (c),
      .done   (done)
   );

endmodule

// File: rtl/mmul_checker.sv
module mmul_checker #(
   parameter int W = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic [2:0]     mode,
   input logic [2*W-1:0] result,
   input logic           z,
   input logic           c,
   input logic           done
);

   AST_START_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> ##2 done); // R5

   AST_DONE_HAS_START: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(start, 2)); // R5

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(result) && $stable(z) && $stable(c))); // R9

   AST_ZERO_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (z == (result == '0))); // R7

   AST_FRAC_LSB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(start, 2) && $past(mode[2], 2)) |-> !result[0]); // R4

endmodule

bind mmul_unit mmul_checker #(.W(W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .mode   (mode),
   .result (result),
   .z      (z),
   .c      (c),
   .done   (done)
);

// File: tb/sim_mmul_unit.sv
module sim_mmul_unit;

   localparam int CLK_NS = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start;
   logic [2:0]  mode;
   logic [7:0]  a;
   logic [7:0]  b;
   logic [15:0] result;
   logic        z;
   logic        c;
   logic        done;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   bit finished = 0;

   typedef struct {
      int          due;
      logic [15:0] r;
      logic        zf;
      logic        cf;
      string       tag;
   } exp_t;

   exp_t        q[$];
   logic [15:0] last_r = '0;
   logic        last_z = 1'b0;
   logic        last_c = 1'b0;

   mmul_unit u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .a(a), .b(b),
      .result(result), .z(z), .c(c), .done(done)
   );

   always #(CLK_NS/2) clk = ~clk;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h cycle=%0d", tag, act, expv, cyc);
      end
   endtask

   // behavioural product with integer arithmetic
   function automatic exp_t ref_mul(input logic [2:0] m, input logic [7:0] x, input logic [7:0] y);
      exp_t e;
      int ia, ib, p;
      logic [15:0] rw;
      ia = (m[1:0] != 2'b00) ? int'($signed(x)) : int'(x);
      ib = (m[1:0] == 2'b01) ? int'($signed(y)) : int'(y);
      p  = ia * ib;
      rw = p[15:0];
      e.r  = m[2] ? {rw[14:0], 1'b0} : rw;
      e.cf = rw[15];
      e.zf = (e.r == 16'h0000);
      case (m)
         3'd0: e.tag = "R1";
         3'd1: e.tag = "R2";
         3'd2, 3'd3, 3'd6, 3'd7: e.tag = "R3";
         default: e.tag = "R4";
      endcase
      if (m == 3'd5 && x == 8'h80 && y == 8'h80) e.tag = "R8";
      e.due = 0;
      return e;
   endfunction

   // called at a falling edge: compare, drive next inputs, advance one cycle
   task automatic step(input logic s, input logic [2:0] m, input logic [7:0] x, input logic [7:0] y);
      exp_t e;
      if (q.size() > 0 && q[0].due == cyc) begin
         e = q.pop_front();
         chk(done == 1'b1, "R5 done", 32'(done), 32'd1);
         chk(result == e.r, e.tag, 32'(result), 32'(e.r));
         chk(c == e.cf, "R6 carry", 32'(c), 32'(e.cf));
         chk(z == e.zf, "R7 zero", 32'(z), 32'(e.zf));
         last_r = e.r; last_z = e.zf; last_c = e.cf;
      end else begin
         chk(done == 1'b0, "R9 no done", 32'(done), 32'd0);
         chk(result == last_r && z == last_z && c == last_c, "R9 hold",
             {15'd0, z, c, result}, {15'd0, last_z, last_c, last_r});
      end
      start = s; mode = m; a = x; b = y;
      if (s) begin
         e = ref_mul(m, x, y);
         e.due = cyc + 2;
         q.push_back(e);
      end
      @(negedge clk);
      cyc++;
   endtask

   initial begin
      #(CLK_NS * 200000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; start = 1'b1; mode = 3'd0; a = 8'hFF; b = 8'hFF;
      repeat (3) @(negedge clk);
      // R10: reset state even with start held high
      chk(done == 1'b0 && result == 16'h0 && z == 1'b0 && c == 1'b0, "R10 reset",
          {15'd0, done, z, c, result}, 32'd0);
      start = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      step(1, 3'd0, 8'hFF, 8'hFF);   // R1 0xFE01, c=1
      step(0, 3'd0, 8'h00, 8'h00);
      step(0, 3'd0, 8'h00, 8'h00);
      step(1, 3'd1, 8'hFF, 8'hFF);   // R2 -1*-1
      step(1, 3'd1, 8'h80, 8'h7F);   // R2 negative
      step(1, 3'd2, 8'hFF, 8'hFF);   // R3 -1*255
      step(1, 3'd3, 8'h80, 8'hFF);   // R3 alternate code
      step(1, 3'd5, 8'h80, 8'h80);   // R8 wrap to 0x8000
      step(1, 3'd4, 8'hFF, 8'hFF);   // R4 frac unsigned
      step(1, 3'd6, 8'hC0, 8'h40);   // R3/R4 frac mixed
      step(1, 3'd7, 8'h01, 8'hFF);   // R3 alternate frac code
      step(1, 3'd1, 8'h00, 8'h80);   // R7 zero
      step(1, 3'd4, 8'h00, 8'h55);   // R7 zero in frac
      step(1, 3'd0, 8'h12, 8'h34);   // R1
      step(0, 3'd0, 8'hAA, 8'hBB);   // R9 idle with live operands
      step(0, 3'd5, 8'h80, 8'h80);
      step(0, 3'd0, 8'h00, 8'h00);
      step(1, 3'd5, 8'h7F, 8'h80);   // R4 frac signed
      step(0, 3'd0, 8'h00, 8'h00);
      step(1, 3'd1, 8'h7F, 8'h7F);
      for (int i = 0; i < 400; i++) begin
         step(logic'($urandom_range(0, 3) != 0), 3'($urandom), 8'($urandom), 8'($urandom));
      end
      for (int i = 0; i < 4; i++) step(0, 3'd0, 8'h00, 8'h00);
      chk(q.size() == 0, "R5 drained", 32'(q.size()), 32'd0);
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule